// File: doc/BRIEF.md
# Calendar Init-Mode and Shadow Synchroniser

This block sits between a fast bus-side register interface and a calendar counter that runs on a slow clock. Software stops the calendar by raising an initialisation request bit. The slow side freezes the counter and reports this back. The bus side shows an acknowledge flag only after the freeze has really happened. While both the request and the acknowledge are high, software may write new time and date values. Clearing the request makes the slow side apply the written fields and restart counting.

The calendar arithmetic is not part of the block. An external incrementer presents the next time and date words, and a tick strobe tells the block when to take them. On each accepted tick, and on each exit from initialisation, the slow side publishes a snapshot. The bus side copies that snapshot into its shadow registers and sets a freshness flag. Software can clear the flag, so it can tell when a later refresh has arrived.

Every flag that crosses between the two clocks goes through a two-stage synchroniser. Multi-bit values cross only under a toggle handshake or while they are held still.

Top module: `cal_init_sync`

## Requirements
- R1: Reset state. While reset is held, `init_req_o`, `init_ack_o`, `sync_flag_o` and `cal_frozen_o` are 0. Both shadows and both calendar words are 0.
- R2: A write with `wr_sel`=0 (control) loads `wr_data[0]` into the request bit. After the request rises, `cal_frozen_o` rises first. `init_ack_o` rises only after that, within 64 bus cycles.
- R3: While `cal_frozen_o` is 1, `cal_tick` is ignored. The calendar words and the bus shadows keep their values.
- R4: A write with `wr_sel`=1 (time) or `wr_sel`=2 (date) is taken only when `init_req_o` and `init_ack_o` are both 1. Otherwise it is ignored. This includes a write sent after the request has been set but before the acknowledge arrives, and a write sent just after the request has been cleared.
- R5: When the frozen state ends, each field written during that request replaces the calendar word. An unwritten field keeps its value. The shadows then show the resulting words, and the sync flag is set.
- R6: After the request bit is cleared, `cal_frozen_o` falls, then `init_ack_o` falls. After that, ticks advance the calendar again.
- R7: A tick while not frozen loads `cal_next_time`/`cal_next_date` into the calendar on that slow edge. The shadows take the same values within 12 bus cycles, and the sync flag is set.
- R8: A control write with `wr_data[1]`=0 clears the sync flag. A control write with `wr_data[1]`=1 leaves the flag unchanged.
- R9: When a shadow refresh and a clearing control write land in the same bus cycle, the flag ends set.
- R10: Setting the request again while `init_ack_o` is already 1 keeps the acknowledge at 1. No new wait is needed, and fields already written stay pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Bus clock |
| rst_bus | input | 1 | Synchronous active-high reset, bus domain |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 time, 2 date |
| wr_data | input | 24 | Write data; control uses bit 0 (request) and bit 1 (keep sync flag) |
| init_req_o | output | 1 | Current request bit |
| init_ack_o | output | 1 | Frozen state seen on the bus side |
| sync_flag_o | output | 1 | Shadows refreshed since last clear |
| time_shadow_o | output | 24 | Bus-side copy of the time word |
| date_shadow_o | output | 24 | Bus-side copy of the date word |
| clk_cal | input | 1 | Slow calendar clock |
| rst_cal | input | 1 | Synchronous active-high reset, calendar domain |
| cal_tick | input | 1 | Advance strobe from the calendar arithmetic |
| cal_next_time | input | 24 | Next time word from the calendar arithmetic |
| cal_next_date | input | 24 | Next date word from the calendar arithmetic |
| cal_time_o | output | 24 | Current calendar time word |
| cal_date_o | output | 24 | Current calendar date word |
| cal_frozen_o | output | 1 | Calendar stopped for initialisation |

## Verification
Two functions can fall in the same bus cycle: the hardware refresh of the shadows, which sets the sync flag, and a software control write that clears it. The bench first clears the flag and times how many bus cycles pass between a tick and the flag rising. It then repeats the tick and places a clearing write one cycle before that point, exactly on it, and one cycle after it. The flag must end set in the first two cases and cleared in the third.

// File: rtl/cal_sync_pkg.sv
package cal_sync_pkg;

    parameter int CS_FIELD_W     = 24;
    parameter int CS_SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_TIME = 2'd1,
        SEL_DATE = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    localparam int CTRL_REQ_BIT  = 0;
    localparam int CTRL_KEEP_BIT = 1;

    typedef struct packed {
        logic [CS_FIELD_W-1:0] date;
        logic [CS_FIELD_W-1:0] tod;
    } stamp_t;

    typedef struct packed {
        logic date;
        logic tod;
    } load_mask_t;

    // Replace only the fields flagged in the mask.
    function automatic stamp_t merge_stamp(stamp_t cur, stamp_t ld, load_mask_t m);
        stamp_t r;
        r.tod  = m.tod  ? ld.tod  : cur.tod;
        r.date = m.date ? ld.date : cur.date;
        return r;
    endfunction

endpackage

// File: rtl/cs_sync2.sv
module cs_sync2 #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= '0;
                    else     chain[g] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= '0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cs_cal_core.sv
module cs_cal_core
    import cal_sync_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req,
    input  logic       tick,
    input  stamp_t     next_val,
    input  stamp_t     load_val,
    input  load_mask_t load_mask,
    output stamp_t     cur,
    output stamp_t     snap,
    output logic       snap_tog,
    output logic       frozen
);
    stamp_t applied;

    always_comb applied = merge_stamp(cur, load_val, load_mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            frozen   <= 1'b0;
            cur      <= '0;
            snap     <= '0;
            snap_tog <= 1'b0;
        end else if (!frozen && req) begin
            // Entering init mode: counter stops, any tick in this cycle is dropped.
            frozen <= 1'b1;
        end else if (frozen && !req) begin
            // Leaving init mode: apply written fields and publish them.
            frozen   <= 1'b0;
            cur      <= applied;
            snap     <= applied;
            snap_tog <= ~snap_tog;
        end else if (!frozen && tick) begin
            cur      <= next_val;
            snap     <= next_val;
            snap_tog <= ~snap_tog;
        end
    end
endmodule

// File: rtl/cs_bus_regs.sv
module cs_bus_regs
    import cal_sync_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  reg_sel_e              wr_sel,
    input  logic [CS_FIELD_W-1:0] wr_data,
    input  logic                  ack,
    input  logic                  shadow_pulse,
    input  stamp_t                snap,
    output logic                  req,
    output logic                  sync_flag,
    output stamp_t                shadow,
    output stamp_t                load_val,
    output load_mask_t            load_mask
);
    logic ctrl_wr;
    logic load_open;
    logic time_wr;
    logic date_wr;

    always_comb begin
        ctrl_wr   = wr_en && (wr_sel == SEL_CTRL);
        load_open = req && ack;
        time_wr   = wr_en && (wr_sel == SEL_TIME) && load_open;
        date_wr   = wr_en && (wr_sel == SEL_DATE) && load_open;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req       <= 1'b0;
            sync_flag <= 1'b0;
            shadow    <= '0;
            load_val  <= '0;
            load_mask <= '0;
        end else begin
            if (ctrl_wr) begin
                req <= wr_data[CTRL_REQ_BIT];
                if (wr_data[CTRL_REQ_BIT] && !req) load_mask <= '0;
            end
            if (time_wr) begin
                load_val.tod  <= wr_data;
                load_mask.tod <= 1'b1;
            end
            if (date_wr) begin
                load_val.date  <= wr_data;
                load_mask.date <= 1'b1;
            end
            // Hardware refresh takes priority over a software clear.
            if (shadow_pulse) begin
                shadow    <= snap;
                sync_flag <= 1'b1;
            end else if (ctrl_wr && !wr_data[CTRL_KEEP_BIT]) begin
                sync_flag <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cal_init_sync.sv
module cal_init_sync
    import cal_sync_pkg::*;
(
    input  logic                  clk_bus,
    input  logic                  rst_bus,
    input  logic                  wr_en,
    input  logic [1:0]            wr_sel,
    input  logic [CS_FIELD_W-1:0] wr_data,
    output logic                  init_req_o,
    output logic                  init_ack_o,
    output logic                  sync_flag_o,
    output logic [CS_FIELD_W-1:0] time_shadow_o,
    output logic [CS_FIELD_W-1:0] date_shadow_o,
    input  logic                  clk_cal,
    input  logic                  rst_cal,
    input  logic                  cal_tick,
    input  logic [CS_FIELD_W-1:0] cal_next_time,
    input  logic [CS_FIELD_W-1:0] cal_next_date,
    output logic [CS_FIELD_W-1:0] cal_time_o,
    output logic [CS_FIELD_W-1:0] cal_date_o,
    output logic                  cal_frozen_o
);
    logic       req_bus;
    logic       req_cal;
    logic       frozen;
    logic       ack_bus;
    logic       snap_tog;
    logic       tog_bus;
    logic       tog_prev;
    logic       shadow_pulse;
    stamp_t     next_val;
    stamp_t     cur;
    stamp_t     snap;
    stamp_t     shadow;
    stamp_t     load_val;
    load_mask_t load_mask;

    always_comb begin
        next_val.tod  = cal_next_time;
        next_val.date = cal_next_date;
    end

    cs_sync2 #(.WIDTH(1), .STAGES(CS_SYNC_STAGES)) u_req_sync (
        .clk(clk_cal), .rst(rst_cal), .d(req_bus), .q(req_cal)
    );

    cs_cal_core u_core (
        .clk(clk_cal), .rst(rst_cal), .req(req_cal), .tick(cal_tick),
        .next_val(next_val), .load_val(load_val), .load_mask(load_mask),
        .cur(cur), .snap(snap), .snap_tog(snap_tog), .frozen(frozen)
    );

    cs_sync2 #(.WIDTH(1), .STAGES(CS_SYNC_STAGES)) u_ack_sync (
        .clk(clk_bus), .rst(rst_bus), .d(frozen), .q(ack_bus)
    );

    cs_sync2 #(.WIDTH(1), .STAGES(CS_SYNC_STAGES)) u_tog_sync (
        .clk(clk_bus), .rst(rst_bus), .d(snap_tog), .q(tog_bus)
    );

    always_ff @(posedge clk_bus) begin
        if (rst_bus) tog_prev <= 1'b0;
        else         tog_prev <= tog_bus;
    end

    assign shadow_pulse = tog_bus ^ tog_prev;

    cs_bus_regs u_bus (
        .clk(clk_bus), .rst(rst_bus), .wr_en(wr_en), .wr_sel(reg_sel_e'(wr_sel)),
        .wr_data(wr_data), .ack(ack_bus), .shadow_pulse(shadow_pulse), .snap(snap),
        .req(req_bus), .sync_flag(sync_flag_o), .shadow(shadow),
        .load_val(load_val), .load_mask(load_mask)
    );

    assign init_req_o    = req_bus;
    assign init_ack_o    = ack_bus;
    assign time_shadow_o = shadow.tod;
    assign date_shadow_o = shadow.date;
    assign cal_time_o    = cur.tod;
    assign cal_date_o    = cur.date;
    assign cal_frozen_o  = frozen;
endmodule

// File: rtl/cal_init_sync_chk.sv
module cal_init_sync_chk
    import cal_sync_pkg::*;
(
    input logic                  clk_bus,
    input logic                  rst_bus,
    input logic                  clk_cal,
    input logic                  rst_cal,
    input logic                  wr_en,
    input logic [1:0]            wr_sel,
    input logic [CS_FIELD_W-1:0] wr_data,
    input logic                  init_ack_o,
    input logic                  sync_flag_o,
    input logic                  shadow_pulse,
    input logic                  cal_frozen_o,
    input logic                  req_cal,
    input logic [CS_FIELD_W-1:0] cal_time_o,
    input logic [CS_FIELD_W-1:0] cal_date_o
);
    assert_ack_after_freeze_R2: assert property (@(posedge clk_bus) disable iff (rst_bus)
        $rose(init_ack_o) |-> cal_frozen_o);

    assert_freeze_needs_request_R2: assert property (@(posedge clk_cal) disable iff (rst_cal)
        $rose(cal_frozen_o) |-> $past(req_cal));

    assert_hold_while_frozen_R3: assert property (@(posedge clk_cal) disable iff (rst_cal)
        (cal_frozen_o && $past(cal_frozen_o)) |-> ($stable(cal_time_o) && $stable(cal_date_o)));

    assert_leave_after_release_R6: assert property (@(posedge clk_cal) disable iff (rst_cal)
        $fell(cal_frozen_o) |-> !$past(req_cal));

    assert_clear_needs_write_R8: assert property (@(posedge clk_bus) disable iff (rst_bus)
        $fell(sync_flag_o) |-> $past(wr_en && (wr_sel == SEL_CTRL) && !wr_data[CTRL_KEEP_BIT]));

    assert_refresh_sets_flag_R9: assert property (@(posedge clk_bus) disable iff (rst_bus)
        shadow_pulse |=> sync_flag_o);
endmodule

bind cal_init_sync cal_init_sync_chk u_chk (
    .clk_bus(clk_bus), .rst_bus(rst_bus), .clk_cal(clk_cal), .rst_cal(rst_cal),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .init_ack_o(init_ack_o), .sync_flag_o(sync_flag_o), .shadow_pulse(shadow_pulse),
    .cal_frozen_o(cal_frozen_o), .req_cal(req_cal),
    .cal_time_o(cal_time_o), .cal_date_o(cal_date_o)
);

// File: tb/sim_cal_init_sync.sv
module sim_cal_init_sync;
    import cal_sync_pkg::*;

    localparam int W = CS_FIELD_W;
    localparam int NV = 4;
    // Each entry: {next date, next time, expected sync flag}
    localparam logic [2*W:0] VEC [NV] = '{
        {24'h250101, 24'h000001, 1'b1},
        {24'h250102, 24'h235959, 1'b1},
        {24'h991231, 24'h120000, 1'b1},
        {24'h000000, 24'hABCDEF, 1'b1}
    };

    logic         clk_bus = 1'b0;
    logic         clk_cal = 1'b0;
    logic         rst_bus = 1'b1;
    logic         rst_cal = 1'b1;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_sel = 2'd3;
    logic [W-1:0] wr_data = '0;
    logic         cal_tick = 1'b0;
    logic [W-1:0] cal_next_time = '0;
    logic [W-1:0] cal_next_date = '0;
    logic         init_req_o, init_ack_o, sync_flag_o, cal_frozen_o;
    logic [W-1:0] time_shadow_o, date_shadow_o, cal_time_o, cal_date_o;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #2 clk_bus = ~clk_bus;
    initial begin
        #1;
        forever #8 clk_cal = ~clk_cal;
    end

    cal_init_sync u0 (
        .clk_bus(clk_bus), .rst_bus(rst_bus), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .init_req_o(init_req_o), .init_ack_o(init_ack_o),
        .sync_flag_o(sync_flag_o), .time_shadow_o(time_shadow_o),
        .date_shadow_o(date_shadow_o), .clk_cal(clk_cal), .rst_cal(rst_cal),
        .cal_tick(cal_tick), .cal_next_time(cal_next_time),
        .cal_next_date(cal_next_date), .cal_time_o(cal_time_o),
        .cal_date_o(cal_date_o), .cal_frozen_o(cal_frozen_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] sel, input logic [W-1:0] d);
        @(negedge clk_bus);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk_bus);
        wr_en = 1'b0; wr_sel = 2'd3;
    endtask

    task automatic tick_once(input logic [W-1:0] t, input logic [W-1:0] d);
        @(negedge clk_cal);
        cal_next_time = t; cal_next_date = d; cal_tick = 1'b1;
        @(negedge clk_cal);
        cal_tick = 1'b0;
    endtask

    task automatic wait_slow(input int n);
        for (int i = 0; i < n; i++) @(negedge clk_cal);
    endtask

    task automatic wait_ack(input logic want, output int cyc);
        cyc = -1;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk_bus);
            if (init_ack_o === want) begin cyc = i; break; end
        end
    endtask

    // Tick, then drive a clearing control write at bus offset 'off' (-1: none).
    task automatic tick_trial(input int off, output int first_hi, output logic final_val);
        first_hi = -1;
        @(negedge clk_cal);
        cal_next_time = cal_time_o + 1'b1; cal_next_date = cal_date_o; cal_tick = 1'b1;
        for (int j = 0; j < 16; j++) begin
            @(negedge clk_bus);
            if (j == 3) cal_tick = 1'b0;
            if (first_hi < 0 && sync_flag_o) first_hi = j;
            wr_en = (j == off); wr_sel = SEL_CTRL; wr_data = '0;
        end
        @(negedge clk_bus);
        wr_en = 1'b0; wr_sel = 2'd3;
        final_val = sync_flag_o;
    endtask

    initial begin
        int cyc;
        int lat;
        int hi;
        logic fv;
        logic [W-1:0] keep_t, keep_d;

        wait_slow(5);
        @(negedge clk_bus);
        // R1: values while reset is still held
        chk("R1 req", init_req_o, 0);
        chk("R1 ack", init_ack_o, 0);
        chk("R1 sync", sync_flag_o, 0);
        chk("R1 frozen", cal_frozen_o, 0);
        chk("R1 shadows", {time_shadow_o, date_shadow_o}, 0);
        chk("R1 cal", {cal_time_o, cal_date_o}, 0);
        rst_bus = 1'b0; rst_cal = 1'b0;
        wait_slow(2);

        // Table walk: R7 refresh, R8 clear
        for (int i = 0; i < NV; i++) begin
            bus_write(SEL_CTRL, '0);
            chk("R8 clear", sync_flag_o, 0);
            tick_once(VEC[i][W:1], VEC[i][2*W:W+1]);
            wait_slow(3);
            chk("R7 cal time", cal_time_o, VEC[i][W:1]);
            chk("R7 cal date", cal_date_o, VEC[i][2*W:W+1]);
            chk("R7 time shadow", time_shadow_o, VEC[i][W:1]);
            chk("R7 date shadow", date_shadow_o, VEC[i][2*W:W+1]);
            chk("R7 sync", sync_flag_o, VEC[i][0]);
        end
        keep_t = cal_time_o; keep_d = cal_date_o;

        // R8: keep bit set leaves the flag alone
        bus_write(SEL_CTRL, 24'h2);
        chk("R8 keep", sync_flag_o, 1);

        // R4: write before ack, then write right after release
        bus_write(SEL_CTRL, 24'h3);
        bus_write(SEL_TIME, 24'h123456);
        wait_ack(1'b1, cyc);
        chk("R2 ack rises", (cyc >= 0), 1);
        chk("R2 frozen", cal_frozen_o, 1);
        tick_once(24'h777777, 24'h777777);
        wait_slow(2);
        chk("R3 cal held", {cal_time_o, cal_date_o}, {keep_t, keep_d});
        chk("R3 shadow held", {time_shadow_o, date_shadow_o}, {keep_t, keep_d});
        bus_write(SEL_CTRL, 24'h2);
        bus_write(SEL_DATE, 24'h654321);
        wait_ack(1'b0, cyc);
        chk("R6 ack falls", (cyc >= 0), 1);
        chk("R6 frozen low", cal_frozen_o, 0);
        wait_slow(2);
        chk("R4 time ignored", cal_time_o, keep_t);
        chk("R4 date ignored", cal_date_o, keep_d);

        // R10 re-request, R5 partial/full load
        bus_write(SEL_CTRL, 24'h3);
        wait_ack(1'b1, cyc);
        chk("R2 ack again", (cyc >= 0), 1);
        bus_write(SEL_TIME, 24'h101010);
        bus_write(SEL_CTRL, 24'h1);
        chk("R10 ack stays", init_ack_o, 1);
        chk("R8 clear in init", sync_flag_o, 0);
        bus_write(SEL_DATE, 24'h202020);
        wait_slow(2);
        chk("R3 no refresh in init", sync_flag_o, 0);
        bus_write(SEL_CTRL, 24'h2);
        wait_ack(1'b0, cyc);
        wait_slow(2);
        chk("R5 cal time", cal_time_o, 24'h101010);
        chk("R5 cal date", cal_date_o, 24'h202020);
        chk("R5 shadows", {time_shadow_o, date_shadow_o}, {24'h101010, 24'h202020});
        chk("R5 sync", sync_flag_o, 1);

        // R5: only time written, date keeps
        bus_write(SEL_CTRL, 24'h3);
        wait_ack(1'b1, cyc);
        bus_write(SEL_TIME, 24'h0A0B0C);
        bus_write(SEL_CTRL, 24'h2);
        wait_ack(1'b0, cyc);
        wait_slow(2);
        chk("R5 partial time", cal_time_o, 24'h0A0B0C);
        chk("R5 partial date", cal_date_o, 24'h202020);

        // R6: counting resumes
        tick_once(24'h111111, 24'h222222);
        wait_slow(3);
        chk("R6 resumes", {cal_time_o, cal_date_o}, {24'h111111, 24'h222222});

        // R9: refresh versus clear in the same cycle
        bus_write(SEL_CTRL, '0);
        tick_trial(-1, lat, fv);
        chk("R7 latency bound", (lat >= 2 && lat <= 12), 1);
        bus_write(SEL_CTRL, '0);
        tick_trial(lat - 2, hi, fv);
        chk("R9 clear before refresh", fv, 1);
        bus_write(SEL_CTRL, '0);
        tick_trial(lat - 1, hi, fv);
        chk("R9 same cycle set wins", fv, 1);
        bus_write(SEL_CTRL, '0);
        tick_trial(lat, hi, fv);
        chk("R9 clear after refresh", fv, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule